// File: doc/BRIEF.md
# Card Bus Clock Generator

This block derives the clock for a removable memory card bus from the system clock. A programmable divider sets the normal card clock rate. While the bus carries no transfer, a power-save mode can slow the clock by a further power of two. During a transfer, optional stall guards hold the card clock low when the local FIFO cannot keep up:

- on a read, the guard stops the clock while the FIFO is full;
- on a write, the guard stops the clock while the FIFO is empty.

These guards favour data integrity over bandwidth.

Alongside the card clock, the block produces a one-system-cycle strobe that marks each rising edge. The command and data line engines use this strobe to move their bits. The clock is always held low when stopped, and every change of rate takes effect at a phase boundary. As a result, the card never sees a shortened pulse.

The core is a four-state machine:

- **OFF**: disabled, clock low.
- **LOW**: counting the low half-period.
- **HIGH**: counting the high half-period.
- **HOLD**: stalled, clock low.

The transitions are:

| From | To | Condition |
|------|----|-----------|
| OFF | LOW | `en` rises |
| LOW | HIGH | low count ends and no stall |
| LOW | HOLD | low count ends and a stall guard is active |
| LOW | OFF | `en` cleared |
| HIGH | LOW | high count ends and `en` still set |
| HIGH | OFF | high count ends and `en` cleared |
| HOLD | HIGH | stall clears |
| HOLD | OFF | `en` cleared |

The half-period length is latched on entry to LOW from OFF and on every entry to HIGH. That length then governs the high phase and the low phase that follows it.

Top module: `mmc_clkgen`

## Requirements
- R1: While `en` is 0, including from reset onward, `card_clk` is 0 and `rise_stb` is 0.
- R2: With power save not in effect, each high phase and each low phase of `card_clk` lasts `clkdiv`+1 system cycles.
- R3: `rise_stb` is 1 in exactly the first system cycle of each high phase of `card_clk`, and 0 in every other cycle.
- R4: When `pws_en`=1 and `bus_active`=0, each phase lasts (`clkdiv`+1)·2^(P+1) system cycles. Here P is `pws_div`, except that a `pws_div` of 0 is used as P=1.
- R5: Power-save division has no effect when `bus_active`=1 or when `pws_en`=0.
- R6: Read stall. When `rd_proof`=1, `bus_active`=1, `dir_write`=0 and `fifo_full`=1, the clock completes its current low phase and then stays low. The next high phase begins one cycle after `fifo_full` falls.
- R7: Write stall. When `wr_proof`=1, `bus_active`=1, `dir_write`=1 and `fifo_empty`=1, the clock stays low in the same way. It resumes one cycle after `fifo_empty` falls.
- R8: Each stall guard acts only in its own direction and only when its enable bit is set. A full FIFO during a write, or during a read with `rd_proof`=0, leaves the clock running.
- R9: A change of `clkdiv` or of power-save mode takes effect only at the start of a high phase. The current period completes with equal high and low lengths at the old rate.
- R10: After `en` rises, the first high phase starts after one full low phase, one half-period plus one cycle after `en` is sampled. Clearing `en` ends the clock at its next low phase, and re-enabling restarts the counters from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Clock generator enable |
| clkdiv | input | DIV_W | Base divider value; half-period is clkdiv+1 cycles |
| pws_en | input | 1 | Power-save enable |
| pws_div | input | 3 | Power-save exponent; extra divide by 2^(P+1), 0 used as 1 |
| rd_proof | input | 1 | Stop the clock on reads while the FIFO is full |
| wr_proof | input | 1 | Stop the clock on writes while the FIFO is empty |
| bus_active | input | 1 | A command or data transfer is in progress |
| dir_write | input | 1 | Transfer direction: 1 write to card, 0 read from card |
| fifo_full | input | 1 | FIFO cannot accept more data |
| fifo_empty | input | 1 | FIFO holds no data to send |
| card_clk | output | 1 | Card bus clock |
| rise_stb | output | 1 | One-cycle strobe in the first cycle of each card_clk high phase |

## Verification
The assertions check the following on every cycle:
- A disabled generator whose clock is low keeps it low.
- The strobe coincides exactly with each rising edge of `card_clk`.
- An active read or write stall guard never lets a low clock rise.

Only the bench's scenarios can show the remaining behaviour:
- The phase lengths for each divider and power-save setting.
- The one-cycle resume latency after a stall clears.
- The deferral of a mid-period rate change to the next high phase.
- The first-rise latency after enabling.

The bench covers these with arithmetic sweeps over the divider and power-save settings.

// File: rtl/mmc_clk_pkg.sv
package mmc_clk_pkg;

    // States of the card clock sequencer
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,   // disabled, clock low
        ST_LOW  = 2'd1,   // counting the low half-period
        ST_HIGH = 2'd2,   // counting the high half-period
        ST_HOLD = 2'd3    // stalled by a FIFO guard, clock low
    } ckst_e;

    // Width of the power-save exponent field
    localparam int PWS_W = 3;

    // Counter width needed for a given divider width
    function automatic int cnt_width(input int div_w);
        return div_w + (1 << PWS_W) + 1;
    endfunction

endpackage

// File: rtl/mmc_clk_halfsel.sv
// Computes the half-period length in system cycles for the current settings.
module mmc_clk_halfsel
    import mmc_clk_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int CNT_W = cnt_width(DIV_W)
) (
    input  logic [DIV_W-1:0] clkdiv,
    input  logic             pws_en,
    input  logic [PWS_W-1:0] pws_div,
    input  logic             bus_active,
    output logic [CNT_W-1:0] half_len
);

    logic             pws_on;
    logic [PWS_W-1:0] exp_eff;
    logic [PWS_W:0]   shamt;
    logic [CNT_W-1:0] base_len;

    always_comb begin
        pws_on   = pws_en && !bus_active;
        exp_eff  = (pws_div == '0) ? PWS_W'(1) : pws_div;
        shamt    = {1'b0, exp_eff} + (PWS_W+1)'(1);
        base_len = CNT_W'(clkdiv) + CNT_W'(1);
        half_len = pws_on ? (base_len << shamt) : base_len;
    end

endmodule

// File: rtl/mmc_clk_stallgate.sv
// Decides whether the FIFO guards must freeze the card clock.
module mmc_clk_stallgate (
    input  logic rd_proof,
    input  logic wr_proof,
    input  logic bus_active,
    input  logic dir_write,
    input  logic fifo_full,
    input  logic fifo_empty,
    output logic stall
);

    logic rd_block;
    logic wr_block;

    always_comb begin
        rd_block = rd_proof && bus_active && !dir_write && fifo_full;
        wr_block = wr_proof && bus_active &&  dir_write && fifo_empty;
        stall    = rd_block || wr_block;
    end

endmodule

// File: rtl/mmc_clk_fsm.sv
// State machine and half-period counter producing the card clock and strobe.
module mmc_clk_fsm
    import mmc_clk_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             stall,
    input  logic [CNT_W-1:0] half_len,
    output logic             card_clk,
    output logic             rise_stb
);

    ckst_e            st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [CNT_W-1:0] hl_q, hl_n;
    logic             cnt_done;
    logic             clk_q, stb_q;

    assign cnt_done = (cnt_q == hl_q - CNT_W'(1));

    // Next-state and counter logic
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        hl_n  = hl_q;
        unique case (st_q)
            ST_OFF: begin
                cnt_n = '0;
                if (en) begin
                    st_n = ST_LOW;
                    hl_n = half_len;
                end
            end
            ST_LOW: begin
                if (!en) begin
                    st_n  = ST_OFF;
                    cnt_n = '0;
                end else if (cnt_done) begin
                    cnt_n = '0;
                    if (stall) begin
                        st_n = ST_HOLD;
                    end else begin
                        st_n = ST_HIGH;
                        hl_n = half_len;
                    end
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            ST_HIGH: begin
                if (cnt_done) begin
                    cnt_n = '0;
                    st_n  = en ? ST_LOW : ST_OFF;
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            ST_HOLD: begin
                cnt_n = '0;
                if (!en) begin
                    st_n = ST_OFF;
                end else if (!stall) begin
                    st_n = ST_HIGH;
                    hl_n = half_len;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            cnt_q <= '0;
            hl_q  <= CNT_W'(1);
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            hl_q  <= hl_n;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q <= 1'b0;
            stb_q <= 1'b0;
        end else begin
            clk_q <= (st_n == ST_HIGH);
            stb_q <= (st_n == ST_HIGH) && (st_q != ST_HIGH);
        end
    end

    assign card_clk = clk_q;
    assign rise_stb = stb_q;

endmodule

// File: rtl/mmc_clkgen.sv
// Top: card bus clock generator with power save and FIFO stall guards.
module mmc_clkgen
    import mmc_clk_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] clkdiv,
    input  logic             pws_en,
    input  logic [2:0]       pws_div,
    input  logic             rd_proof,
    input  logic             wr_proof,
    input  logic             bus_active,
    input  logic             dir_write,
    input  logic             fifo_full,
    input  logic             fifo_empty,
    output logic             card_clk,
    output logic             rise_stb
);

    localparam int CNT_W = cnt_width(DIV_W);

    logic [CNT_W-1:0] half_len;
    logic             stall;

    mmc_clk_halfsel #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_half (
        .clkdiv     (clkdiv),
        .pws_en     (pws_en),
        .pws_div    (pws_div),
        .bus_active (bus_active),
        .half_len   (half_len)
    );

    mmc_clk_stallgate u_stall (
        .rd_proof   (rd_proof),
        .wr_proof   (wr_proof),
        .bus_active (bus_active),
        .dir_write  (dir_write),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .stall      (stall)
    );

    mmc_clk_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .stall    (stall),
        .half_len (half_len),
        .card_clk (card_clk),
        .rise_stb (rise_stb)
    );

endmodule

// File: rtl/mmc_clkgen_chk.sv
// Checker for the card clock generator, attached by bind.
module mmc_clkgen_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic rd_proof,
    input logic wr_proof,
    input logic bus_active,
    input logic dir_write,
    input logic fifo_full,
    input logic fifo_empty,
    input logic card_clk,
    input logic rise_stb
);

    // R1: a disabled generator with a low clock keeps it low and silent
    p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !card_clk) |=> (!card_clk && !rise_stb));

    // R3: every rising edge carries the strobe
    p_rise_has_stb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk) |-> rise_stb);

    // R3: the strobe appears only on a rising edge
    p_stb_only_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> $rose(card_clk));

    // R6: an active read guard never lets a low clock rise
    p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_proof && bus_active && !dir_write && fifo_full && !card_clk) |=> !card_clk);

    // R7: an active write guard never lets a low clock rise
    p_wr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_proof && bus_active && dir_write && fifo_empty && !card_clk) |=> !card_clk);

endmodule

bind mmc_clkgen mmc_clkgen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .rd_proof   (rd_proof),
    .wr_proof   (wr_proof),
    .bus_active (bus_active),
    .dir_write  (dir_write),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .card_clk   (card_clk),
    .rise_stb   (rise_stb)
);

// File: tb/sim_mmc_clkgen.sv
`timescale 1ns/1ps
module sim_mmc_clkgen;

    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic [DIV_W-1:0] clkdiv = '0;
    logic             pws_en = 1'b0;
    logic [2:0]       pws_div = '0;
    logic             rd_proof = 1'b0;
    logic             wr_proof = 1'b0;
    logic             bus_active = 1'b0;
    logic             dir_write = 1'b0;
    logic             fifo_full = 1'b0;
    logic             fifo_empty = 1'b0;
    logic             card_clk;
    logic             rise_stb;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mmc_clkgen #(.DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .clkdiv(clkdiv),
        .pws_en(pws_en), .pws_div(pws_div), .rd_proof(rd_proof),
        .wr_proof(wr_proof), .bus_active(bus_active), .dir_write(dir_write),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .card_clk(card_clk), .rise_stb(rise_stb)
    );

    function automatic int exp_half(int d, bit pws, int p, bit act);
        if (pws && !act) begin
            int pe = (p == 0) ? 1 : p;
            return (d + 1) * (1 << (pe + 1));
        end
        return d + 1;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Wait for a strobe, then measure one full period: high run, low run,
    // and strobes seen anywhere but the first high cycle.
    task automatic measure(output int h, output int l, output int extra);
        int guard = 0;
        h = 0; l = 0; extra = 0;
        @(negedge clk);
        while (!rise_stb && guard < 5000) begin
            guard++;
            @(negedge clk);
        end
        while (card_clk && h < 5000) begin
            if (rise_stb && h != 0) extra++;
            h++;
            @(negedge clk);
        end
        while (!card_clk && l < 5000) begin
            if (rise_stb) extra++;
            l++;
            @(negedge clk);
        end
    endtask

    task automatic check_period(string req, int hl);
        int h, l, x;
        measure(h, l, x);
        measure(h, l, x);
        chk({req, " high"}, h, hl);
        chk({req, " low"}, l, hl);
        chk("R3 stray strobe", x, 0);
    endtask

    // Count cycles with the clock high or a strobe over n samples.
    task automatic quiet_window(string req, int n);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (card_clk || rise_stb) bad++;
        end
        chk(req, bad, 0);
    endtask

    // Cycles from this negedge until card_clk is first seen high.
    task automatic cycles_to_rise(output int c);
        c = 0;
        do begin
            @(negedge clk);
            c++;
        end while (!card_clk && c < 5000);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int c;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset and disabled state
        quiet_window("R1 disabled after reset", 20);

        // R10: first rise after one full low phase
        clkdiv = 8'd2;
        en = 1'b1;
        cycles_to_rise(c);
        chk("R10 first rise latency", c, 4);

        // R2/R3: base divider sweep
        for (int d = 0; d < 7; d++) begin
            clkdiv = DIV_W'(d);
            check_period("R2 base divider", exp_half(d, 0, 0, 0));
        end

        // R4: power-save sweep while bus idle
        pws_en = 1'b1;
        bus_active = 1'b0;
        for (int d = 0; d < 3; d++) begin
            for (int p = 0; p < 8; p++) begin
                clkdiv = DIV_W'(d);
                pws_div = 3'(p);
                check_period("R4 power save", exp_half(d, 1, p, 0));
            end
        end

        // R5: power save without effect
        clkdiv = 8'd3;
        pws_div = 3'd5;
        bus_active = 1'b1;
        check_period("R5 bus active", 4);
        pws_en = 1'b0;
        bus_active = 1'b0;
        check_period("R5 pws disabled", 4);

        // R9: mid-period rate change waits for the next high phase
        begin
            int h, l;
            clkdiv = 8'd1;
            check_period("R9 setup", 2);
            @(negedge clk);
            while (!rise_stb) @(negedge clk);
            clkdiv = 8'd5;
            h = 0; l = 0;
            while (card_clk) begin h++; @(negedge clk); end
            while (!card_clk) begin l++; @(negedge clk); end
            chk("R9 old high kept", h, 2);
            chk("R9 old low kept", l, 2);
            check_period("R9 new rate", 6);
        end

        // R6: read stall
        clkdiv = 8'd1;
        bus_active = 1'b1;
        dir_write = 1'b0;
        rd_proof = 1'b1;
        check_period("R6 pre-stall", 2);
        fifo_full = 1'b1;
        repeat (12) @(negedge clk);
        quiet_window("R6 read stall holds low", 30);
        fifo_full = 1'b0;
        cycles_to_rise(c);
        chk("R6 resume latency", c, 1);

        // R8: guards limited by direction and enable
        fifo_full = 1'b1;
        dir_write = 1'b1;
        check_period("R8 full during write", 2);
        dir_write = 1'b0;
        rd_proof = 1'b0;
        check_period("R8 read guard off", 2);
        fifo_full = 1'b0;

        // R7: write stall
        wr_proof = 1'b1;
        dir_write = 1'b1;
        check_period("R7 pre-stall", 2);
        fifo_empty = 1'b1;
        repeat (12) @(negedge clk);
        quiet_window("R7 write stall holds low", 30);
        fifo_empty = 1'b0;
        cycles_to_rise(c);
        chk("R7 resume latency", c, 1);

        // R8: empty FIFO during a read does not stop the clock
        fifo_empty = 1'b1;
        dir_write = 1'b0;
        check_period("R8 empty during read", 2);
        fifo_empty = 1'b0;
        wr_proof = 1'b0;

        // R10: disable and re-enable
        clkdiv = 8'd2;
        check_period("R10 pre-disable", 3);
        en = 1'b0;
        repeat (8) @(negedge clk);
        quiet_window("R10 disabled stays low", 20);
        en = 1'b1;
        cycles_to_rise(c);
        chk("R10 restart latency", c, 4);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule